// File: doc/BRIEF.md
# Two-Symbol Lookahead Variable-Length Decoder

This block speeds up a strictly sequential variable-length decode by handing back up to two symbols per call. Each call supplies two bit windows, both MSB-first. The first window is aligned to the codeword being decoded now. The second window is aligned to the codeword whose length was found on the previous call. From the first window the block fully decodes the current codeword: run, level and length. For the codeword that follows, it produces only the length. It does this by running a length estimator at every start offset the current codeword could leave behind, then picking one result by the current length. From the second window it finishes the deferred codeword by producing its run and level. The caller shifts both windows between calls, using the two returned lengths.

Results come out as two 64-bit words. The first holds four signed 16-bit lanes. The second holds eight bytes of lengths and flags, including one combined exit flag. The caller tests that single flag to leave its loop at end-of-block or on a bad code. On the first call of a block there is no deferred codeword, and a dedicated input marks that call.

The code table is fixed by the block. Window bit WIN_W-1 is the first bit of a codeword:

- `10` is end-of-block, length 2.
- `11s` is run 0, level ±1, length 3.
- `01 rr s` is run rr, level ±1, length 5.
- `001 rrr mm s` is run rrr, level ±(mm+1), length 9.
- `0001 rrrrrr llllllllllll` is an escape with a 6-bit run and a 12-bit two's-complement level, length 22.
- `0000` starts an invalid code.

In every sign bit s, a 1 means negative.

Top module: `vlc2_lookahead_dec`

## Requirements
- R1: A call presented with `req` high at a rising edge produces `res_valid` high, together with its `lanes` and `info`, exactly two rising edges later. With `req` low, no result appears.
- R2: The current codeword is decoded from `win_cur` by the short codes of the table: `10` end-of-block (length 2); `11s` run 0, level ±1 (length 3); `01rrs` run rr, level ±1 (length 5); `001rrrmms` run rrr, level ±(mm+1) (length 9). The sign bit s=1 means negative.
- R3: The escape `0001` is followed by a 6-bit run and a 12-bit two's-complement level, length 22. An escape whose level is zero is an error, with length 22. A codeword starting `0000` is an error, with length 0. An error or end-of-block reports run 0 and level 0.
- R4: The next-codeword length is that of the codeword starting exactly current-length bits into `win_cur`. Its valid, end-of-block and error flags are reported the same way.
- R5: The deferred codeword's run and level are decoded from `win_prev` with the same table, and its flags are reported.
- R6: When `first_call` is set, the deferred lanes and the deferred flag byte are zero, and the deferred codeword does not affect the exit flag.
- R7: When the current codeword is end-of-block or an error, the next length is 0 and the next flag byte is 0.
- R8: The exit flag (`info` bit 40) is set exactly when the current codeword, or the deferred codeword on a call that is not a first call, is end-of-block or an error.
- R9: Packing. In `lanes`, bits 15:0 hold the current run, 31:16 the current level, 47:32 the deferred run and 63:48 the deferred level, each a 16-bit two's-complement value. In `info`, byte 0 is the current length and byte 1 the next length. Byte 2 holds the deferred flags, byte 3 the current flags and byte 4 the next flags, each as bit0 valid, bit1 end-of-block, bit2 error. Byte 5 bit 0 is the exit flag, and bytes 6–7 are zero. Valid and error are never both set.
- R10: While the synchronous active-high reset `rst` is applied, `res_valid`, `lanes` and `info` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Call strobe, one call per cycle it is high |
| first_call | input | 1 | Marks the first call of a block (no deferred codeword) |
| win_cur | input | WIN_W | Window aligned to the current codeword, MSB first |
| win_prev | input | WIN_W | Window aligned to the deferred codeword, MSB first |
| res_valid | output | 1 | Result strobe |
| lanes | output | 64 | Four signed 16-bit run/level lanes |
| info | output | 64 | Eight bytes of lengths and flags |

## Verification
Every result is due two rising edges after the edge that samples its `req`. There is one register stage on the inputs and one on the outputs. The driver stamps each expected result in the scoreboard with the cycle number at which it must appear. The monitor samples on the falling edge, checks that the cycle stamp matches and that both result words are equal, and treats any `res_valid` with an empty queue as a fault. Idle gaps, back-to-back calls and the reset state are checked at the same falling-edge sampling point.

// File: rtl/vlc2_pkg.sv
package vlc2_pkg;
  // longest codeword in the table (escape)
  localparam int CODE_MAX = 22;
  localparam int LEN_W    = $clog2(CODE_MAX + 1);
  localparam int RUN_W    = 6;
  localparam int LVL_W    = 16;
  localparam int ESC_LW   = 12;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             ok;   // valid_decode
    logic             eob;
    logic             err;
  } len_info_t;

  function automatic logic [7:0] flag_byte(len_info_t i);
    return {5'b0, i.err, i.eob, i.ok};
  endfunction
endpackage

// File: rtl/vlc_len_est.sv
// Length-only estimator: classifies the codeword at the aperture head.
module vlc_len_est import vlc2_pkg::*; (
  input  logic [CODE_MAX-1:0] ap,
  output len_info_t           info
);
  localparam int H = CODE_MAX - 1;

  always_comb begin
    info = '0;
    if (ap[H]) begin
      info.ok  = 1'b1;
      info.eob = ~ap[H-1];
      info.len = ap[H-1] ? LEN_W'(3) : LEN_W'(2);
    end else if (ap[H-1]) begin
      info.ok  = 1'b1;
      info.len = LEN_W'(5);
    end else if (ap[H-2]) begin
      info.ok  = 1'b1;
      info.len = LEN_W'(9);
    end else if (ap[H-3]) begin
      info.len = LEN_W'(CODE_MAX);
      if (ap[ESC_LW-1:0] == '0) info.err = 1'b1;
      else                      info.ok  = 1'b1;
    end else begin
      info.err = 1'b1;
    end
  end
endmodule

// File: rtl/vlc_sym_dec.sv
// Full decoder: length/flags via the estimator, plus run and level.
module vlc_sym_dec import vlc2_pkg::*; (
  input  logic [CODE_MAX-1:0]     ap,
  output len_info_t               info,
  output logic [RUN_W-1:0]        run,
  output logic signed [LVL_W-1:0] lvl
);
  localparam int H = CODE_MAX - 1;

  logic [LVL_W-1:0] mag;

  vlc_len_est u_len (.ap(ap), .info(info));

  always_comb begin
    run = '0;
    mag = LVL_W'(1);
    lvl = '0;
    if (info.ok && !info.eob) begin
      if (ap[H]) begin
        lvl = ap[H-2] ? -$signed(mag) : $signed(mag);
      end else if (ap[H-1]) begin
        run = RUN_W'(ap[H-2 -: 2]);
        lvl = ap[H-4] ? -$signed(mag) : $signed(mag);
      end else if (ap[H-2]) begin
        run = RUN_W'(ap[H-3 -: 3]);
        mag = LVL_W'(ap[H-6 -: 2]) + LVL_W'(1);
        lvl = ap[H-8] ? -$signed(mag) : $signed(mag);
      end else begin
        run = ap[H-4 -: RUN_W];
        lvl = LVL_W'($signed(ap[ESC_LW-1:0]));
      end
    end
  end
endmodule

// File: rtl/vlc_next_sel.sv
// One length estimator per candidate offset; the current length picks one.
module vlc_next_sel import vlc2_pkg::*; #(
  parameter int WIN_W = 64,
  parameter int NOFF  = CODE_MAX + 1
) (
  input  logic [WIN_W-1:0] win,
  input  logic [LEN_W-1:0] sel,
  output len_info_t        info
);
  len_info_t cand [NOFF];

  for (genvar k = 0; k < NOFF; k++) begin : g_off
    vlc_len_est u_est (.ap(win[WIN_W-1-k -: CODE_MAX]), .info(cand[k]));
  end

  always_comb begin
    info = '0;
    for (int k = 0; k < NOFF; k++)
      if (sel == LEN_W'(k)) info = cand[k];
  end
endmodule

// File: rtl/vlc2_lookahead_dec.sv
module vlc2_lookahead_dec import vlc2_pkg::*; #(
  parameter int WIN_W  = 64,  // must be >= 2*CODE_MAX
  parameter int LANE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic               first_call,
  input  logic [WIN_W-1:0]   win_cur,
  input  logic [WIN_W-1:0]   win_prev,
  output logic               res_valid,
  output logic [4*LANE_W-1:0] lanes,
  output logic [63:0]        info
);
  localparam int NOFF = CODE_MAX + 1;

  // stage 1: input registers
  logic             s1_v, s1_first;
  logic [WIN_W-1:0] s1_cur, s1_prv;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_first <= 1'b0; s1_cur <= '0; s1_prv <= '0;
    end else begin
      s1_v     <= req;
      s1_first <= first_call;
      s1_cur   <= win_cur;
      s1_prv   <= win_prev;
    end
  end

  len_info_t               cur_i, prv_i, nxt_raw, prv_f, nxt_f;
  logic [RUN_W-1:0]        run_c, run_p, run_pf;
  logic signed [LVL_W-1:0] lvl_c, lvl_p, lvl_pf;
  logic                    cur_go, exit_d;
  logic [4*LANE_W-1:0]     lanes_d;
  logic [63:0]             info_d;

  vlc_sym_dec u_cur (.ap(s1_cur[WIN_W-1 -: CODE_MAX]), .info(cur_i), .run(run_c), .lvl(lvl_c));
  vlc_sym_dec u_prv (.ap(s1_prv[WIN_W-1 -: CODE_MAX]), .info(prv_i), .run(run_p), .lvl(lvl_p));

  vlc_next_sel #(.WIN_W(WIN_W), .NOFF(NOFF)) u_nxt (
    .win(s1_cur), .sel(cur_i.len), .info(nxt_raw)
  );

  always_comb begin
    cur_go = cur_i.ok & ~cur_i.eob;
    nxt_f  = cur_go ? nxt_raw : '0;
    prv_f  = s1_first ? '0 : prv_i;
    run_pf = s1_first ? '0 : run_p;
    lvl_pf = s1_first ? '0 : lvl_p;
    exit_d = cur_i.eob | cur_i.err | prv_f.eob | prv_f.err;

    lanes_d = {LANE_W'(lvl_pf), LANE_W'(run_pf), LANE_W'(lvl_c), LANE_W'(run_c)};
    info_d  = {16'h0, 7'h0, exit_d, flag_byte(nxt_f), flag_byte(cur_i),
               flag_byte(prv_f), 8'(nxt_f.len), 8'(cur_i.len)};
  end

  // stage 2: output registers
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0; lanes <= '0; info <= '0;
    end else begin
      res_valid <= s1_v;
      if (s1_v) begin
        lanes <= lanes_d;
        info  <= info_d;
      end
    end
  end
endmodule

// File: rtl/vlc2_lookahead_chk.sv
module vlc2_lookahead_chk (
  input logic        clk,
  input logic        rst,
  input logic        req,
  input logic        first_call,
  input logic        res_valid,
  input logic [63:0] lanes,
  input logic [63:0] info
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (res_valid == $past(req, 2)));

  // R6
  first_call_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && res_valid && $past(first_call, 2)) |->
      (info[23:16] == 8'h0 && lanes[63:32] == 32'h0));

  // R7
  stop_next_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && (info[25] || info[26])) |-> (info[15:8] == 8'h0 && info[39:32] == 8'h0));

  // R8
  exit_flag_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (info[40] == (info[25] | info[26] | info[17] | info[18])));

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($onehot0({info[24], info[26]}) && $onehot0({info[16], info[18]})
                   && $onehot0({info[32], info[34]}) && info[63:41] == '0));

  // R4
  next_needs_cur_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && info[15:8] != 8'h0) |-> (info[24] && !info[25] && info[7:0] != 8'h0));
endmodule

bind vlc2_lookahead_dec vlc2_lookahead_chk chk_i (.*);

// File: tb/vlc2_lookahead_dec_tb.sv
`timescale 1ns/1ps
module vlc2_lookahead_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        first_call = 1'b0;
  logic [63:0] win_cur = '0, win_prev = '0;
  logic        res_valid;
  logic [63:0] lanes, info;

  always #2 clk = ~clk;  // 250 MHz

  vlc2_lookahead_dec dut_i (
    .clk(clk), .rst(rst), .req(req), .first_call(first_call),
    .win_cur(win_cur), .win_prev(win_prev),
    .res_valid(res_valid), .lanes(lanes), .info(info)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [63:0] q_lanes[$], q_info[$];
  int          q_cyc[$];
  string       q_tag[$];

  typedef struct { int len; int run; int lvl; bit v; bit e; bit r; } sym_m;

  // Bench model written from R2/R3: reads bits one at a time.
  function automatic sym_m model(logic [63:0] w, int off);
    sym_m s;
    bit b[0:21];
    int acc;
    s = '{0, 0, 0, 0, 0, 0};
    for (int i = 0; i < 22; i++) b[i] = w[63-off-i];
    if (b[0] && !b[1]) begin s.len = 2; s.v = 1; s.e = 1; end
    else if (b[0]) begin s.len = 3; s.v = 1; s.lvl = b[2] ? -1 : 1; end
    else if (b[1]) begin s.len = 5; s.v = 1; s.run = b[2]*2 + b[3]; s.lvl = b[4] ? -1 : 1; end
    else if (b[2]) begin
      s.len = 9; s.v = 1; s.run = b[3]*4 + b[4]*2 + b[5];
      acc = b[6]*2 + b[7] + 1; s.lvl = b[8] ? -acc : acc;
    end else if (b[3]) begin
      s.len = 22;
      for (int i = 4; i < 10; i++) s.run = s.run*2 + b[i];
      acc = 0;
      for (int i = 10; i < 22; i++) acc = acc*2 + b[i];
      if (acc == 0) begin s.r = 1; s.run = 0; end
      else begin s.v = 1; s.lvl = (acc >= 2048) ? acc - 4096 : acc; end
    end else s.r = 1;
    return s;
  endfunction

  function automatic logic [7:0] fb(sym_m s);
    return {5'b0, s.r, s.e, s.v};
  endfunction

  logic [63:0] wb; int wpos;
  task automatic wstart(); wb = '1; wpos = 0; endtask
  task automatic put(input logic [31:0] bits, input int n);
    for (int i = 0; i < n; i++) wb[63-wpos-i] = bits[n-1-i];
    wpos += n;
  endtask

  // driver: apply one call and push its expected result
  task automatic send(input bit fst, input logic [63:0] wc, input logic [63:0] wpv, input string tag);
    sym_m c, n, p;
    logic [15:0] rc, lc, rp, lp;
    bit ex;
    c = model(wc, 0);
    p = model(wpv, 0);
    n = '{0, 0, 0, 0, 0, 0};
    if (c.v && !c.e) n = model(wc, c.len);
    if (fst) p = '{0, 0, 0, 0, 0, 0};
    rc = (c.v && !c.e) ? 16'(c.run) : 16'h0;
    lc = (c.v && !c.e) ? 16'(c.lvl) : 16'h0;
    rp = (p.v && !p.e) ? 16'(p.run) : 16'h0;
    lp = (p.v && !p.e) ? 16'(p.lvl) : 16'h0;
    ex = c.e | c.r | p.e | p.r;
    req = 1'b1; first_call = fst; win_cur = wc; win_prev = wpv;
    q_lanes.push_back({lp, rp, lc, rc});
    q_info.push_back({16'h0, 7'h0, ex, fb(n), fb(c), fb(p), 8'(n.len), 8'(c.len)});
    q_cyc.push_back(cyc + 2);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int k);
    req = 1'b0; first_call = 1'b0;
    repeat (k) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      n_cmp++;
      if (q_tag.size() == 0) begin
        n_bad++;
        $display("FAIL R1: unexpected result actual info=%h expected none", info);
      end else begin
        automatic logic [63:0] el = q_lanes.pop_front();
        automatic logic [63:0] ei = q_info.pop_front();
        automatic int ec = q_cyc.pop_front();
        automatic string t = q_tag.pop_front();
        if (lanes !== el || info !== ei || cyc != ec) begin
          n_bad++;
          $display("FAIL %s: actual lanes=%h info=%h cyc=%0d expected lanes=%h info=%h cyc=%0d",
                   t, lanes, info, cyc, el, ei, ec);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string msg);
    n_cmp++;
    if (!ok) begin n_bad++; $display("FAIL %s", msg); end
  endtask

  initial begin
    logic [63:0] wc, wpv;
    repeat (3) @(negedge clk);
    // R10
    chk(res_valid === 1'b0 && lanes === '0 && info === '0,
        $sformatf("R10 reset: actual v=%b lanes=%h info=%h expected 0", res_valid, lanes, info));
    rst = 1'b0;
    @(negedge clk);

    // R2 R4 R6: first call, current 11s(-1), next 01 10 0 (run2,+1)
    wstart(); put(3'b111, 3); put(5'b01100, 5); wc = wb;
    wstart(); put(3'b001, 3); wpv = wb;
    send(1, wc, wpv, "R6 first call / R2 / R4");
    idle(3);
    // R1: idle produces nothing
    chk(res_valid === 1'b0, $sformatf("R1 idle: actual v=%b expected 0", res_valid));

    // R5 R4: prev 001 101 11 1 (run5, -4), cur 01 11 1, next escape
    wstart(); put(9'b001101111, 9); wpv = wb;
    wstart(); put(5'b01111, 5); put(4'b0001, 4); put(6'd17, 6); put(12'h7FF, 12); wc = wb;
    send(0, wc, wpv, "R5 deferred / R4 next escape");

    // R3 R4: cur escape run 63 level -2048, next eob
    wstart(); put(4'b0001, 4); put(6'd63, 6); put(12'h800, 12); put(2'b10, 2); wc = wb;
    wstart(); put(3'b110, 3); wpv = wb;
    send(0, wc, wpv, "R3 escape / R4 next eob");

    // R3 R7 R8: escape with zero level
    wstart(); put(4'b0001, 4); put(6'd5, 6); put(12'h000, 12); wc = wb;
    send(0, wc, wpv, "R3 R7 R8 escape zero level");

    // R3 R7 R8: 0000 prefix
    wc = 64'h0FFF_FFFF_FFFF_FFFF;
    send(0, wc, wpv, "R3 R7 R8 invalid prefix");

    // R7 R8: current eob
    wstart(); put(2'b10, 2); wc = wb;
    send(0, wc, wpv, "R7 R8 current eob");

    // R8: deferred eob with a good current codeword
    wstart(); put(2'b10, 2); wpv = wb;
    wstart(); put(3'b110, 3); wc = wb;
    send(0, wc, wpv, "R8 deferred eob");

    // R6: deferred eob ignored on a first call
    send(1, wc, wpv, "R6 R8 first call masks deferred");

    // R4: next codeword at offset 9 is invalid
    wstart(); put(9'b001000000, 9); put(4'b0000, 4); wc = wb;
    send(0, wc, 64'hC000_0000_0000_0000, "R4 next error at offset 9");
    idle(2);

    // R1 R2 R9: back-to-back sweep over run and magnitude
    for (int r = 0; r < 8; r++) begin
      for (int m = 0; m < 4; m++) begin
        wstart(); put(3'b001, 3); put(3'(r), 3); put(2'(m), 2); put(1'(m[0]), 1); wpv = wb;
        wstart(); put(2'b01, 2); put(2'(r), 2); put(1'(r[0]), 1);
        put(3'b001, 3); put(3'(7-r), 3); put(2'(m), 2); put(1'b1, 1); wc = wb;
        send((r == 0 && m == 0), wc, wpv, "R1 R2 R9 sweep");
      end
    end
    idle(4);
    chk(q_tag.size() == 0, $sformatf("R1 drain: actual pending=%0d expected 0", q_tag.size()));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule